// File: doc/BRIEF.md
# Pause-Width Reader Bit Encoder

This block turns a reader-to-tag command word of 1 to 32 bits into a carrier-control waveform on one output line. Every bit opens with a fixed carrier-off gap. A carrier-on stretch follows, and its length tells a one from a zero. Bits leave least significant first. Once the last bit has gone out, one more gap of the same length closes the frame, and the line then returns to carrier-on.

Durations are held in microseconds and converted to clock cycles with a parameterised cycles-per-microsecond ratio. Each nominal duration is shortened by a fixed trim that makes up for overhead elsewhere in the transmit path. A free-running microsecond counter runs beside the encoder. Its value is latched at the moment the closing gap ends, so that logic downstream can time the tag's reply window from the true end of the frame.

Top module: `pause_width_encoder`

## Requirements
- R1: After reset and whenever idle, `carrier_on` is 1, `busy` is 0, `done` is 0, and `end_stamp` is 0 until the first frame completes.
- R2: Each bit, and the closing gap, drives `carrier_on` low for exactly (PAUSE_US-TRIM_US)*CLK_PER_US cycles, which is 16 µs with the defaults. The first gap starts in the cycle after the edge that accepts `start`.
- R3: A data bit equal to 1 is followed by `carrier_on` high for exactly (ONE_ON_US-TRIM_US)*CLK_PER_US cycles, which is 76 µs with the defaults.
- R4: A data bit equal to 0 is followed by `carrier_on` high for exactly (ZERO_ON_US-TRIM_US)*CLK_PER_US cycles, which is 36 µs with the defaults.
- R5: Bits are taken from `tx_word` starting at bit 0 and rising one position per bit, for as many bits as the effective count.
- R6: After the last data bit's carrier-on stretch, exactly one more gap is sent, and then `carrier_on` returns high. A frame of n bits therefore lasts (n+1) gaps plus the sum of the n carrier-on stretches.
- R7: The effective count is `tx_bits` clamped to 1..32: a value of 0 sends one bit, and any value above 32 sends 32 bits.
- R8: A `start` that arrives while `busy` is 1 is ignored. This includes the last cycle of the closing gap. The frame in flight keeps its data, its count and its length.
- R9: `done` is a one-cycle pulse in the first cycle in which `carrier_on` is back high after the closing gap. `busy` is 0 in that same cycle, and a `start` in that cycle is accepted.
- R10: On the edge that ends the closing gap, `end_stamp` latches the microsecond count, which equals floor((k-1)/CLK_PER_US) for the k-th clock edge after reset. `end_stamp` holds that value until the next frame completes.
- R11: `busy` is 1 from the cycle after an accepted `start` up to the cycle before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| tx_word | input | MAX_BITS | Frame bits, sent from bit 0 upward |
| tx_bits | input | $clog2(MAX_BITS+1) | Requested bit count, clamped to 1..MAX_BITS |
| carrier_on | output | 1 | 1 = carrier on, 0 = carrier-off gap |
| busy | output | 1 | A frame is being sent |
| done | output | 1 | One-cycle pulse when the frame ends |
| end_stamp | output | TS_W | Microsecond count latched at frame end |

## Verification
If the segment timer is loaded with the wrong value, or a bit is shifted out of order, the result appears as a misplaced `carrier_on` edge within one gap or carrier stretch, so within about 100 µs of the fault. If the bit index or the clamp is wrong, the frame ends too early or too late, and that shows on `done` and `busy` when the frame ends. If the microsecond counter is wrong, the only visible sign is the value of `end_stamp` at the next `done`. This is why the bench compares every output on every cycle against its own model of the waveform.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GAP     = 2'd1,
    ST_CARRIER = 2'd2
  } pwe_state_t;
endpackage

// File: rtl/pwe_us_clock.sv
module pwe_us_clock #(
  parameter int CLK_PER_US = 125,
  parameter int TS_W       = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] us_now
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      us_now <= '0;
    end else begin
      pre_q <= wrap ? '0 : pre_q + 1'b1;
      if (wrap) us_now <= us_now + 1'b1;
    end
  end
endmodule

// File: rtl/pwe_seg_timer.sv
module pwe_seg_timer #(
  parameter int TMR_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);
  logic [TMR_W-1:0] left_q;

  assign expired = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst)               left_q <= '0;
    else if (load)         left_q <= load_val;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/pwe_frame_seq.sv
module pwe_frame_seq
  import pwe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int TMR_W  = 14,
  parameter int TS_W   = 32,
  parameter logic [TMR_W-1:0] GAP_LD  = '0,
  parameter logic [TMR_W-1:0] ONE_LD  = '0,
  parameter logic [TMR_W-1:0] ZERO_LD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] word_in,
  input  logic [CNT_W-1:0]  bits_in,
  input  logic              tmr_expired,
  input  logic [TS_W-1:0]   us_now,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic              carrier_on,
  output logic              busy,
  output logic              done,
  output logic [TS_W-1:0]   end_stamp
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);

  pwe_state_t        state_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  last_q;
  logic              closing_q;
  logic [CNT_W-1:0]  last_idx;

  always_comb begin
    if (bits_in == '0)         last_idx = '0;
    else if (bits_in > MAX_CNT) last_idx = MAX_CNT - 1'b1;
    else                        last_idx = bits_in - 1'b1;
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = GAP_LD;
    unique case (state_q)
      ST_IDLE:    tmr_load = start;
      ST_GAP: begin
        tmr_load = tmr_expired && !closing_q;
        tmr_val  = shift_q[0] ? ONE_LD : ZERO_LD;
      end
      ST_CARRIER: tmr_load = tmr_expired;
      default:    tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      shift_q    <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      closing_q  <= 1'b0;
      carrier_on <= 1'b1;
      busy       <= 1'b0;
      done       <= 1'b0;
      end_stamp  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            shift_q    <= word_in;
            last_q     <= last_idx;
            idx_q      <= '0;
            closing_q  <= 1'b0;
            carrier_on <= 1'b0;
            busy       <= 1'b1;
            state_q    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_expired) begin
            carrier_on <= 1'b1;
            if (closing_q) begin
              busy      <= 1'b0;
              done      <= 1'b1;
              end_stamp <= us_now;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_CARRIER;
            end
          end
        end
        ST_CARRIER: begin
          if (tmr_expired) begin
            carrier_on <= 1'b0;
            shift_q    <= shift_q >> 1;
            idx_q      <= idx_q + 1'b1;
            if (idx_q == last_q) closing_q <= 1'b1;
            state_q    <= ST_GAP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pause_width_encoder.sv
module pause_width_encoder #(
  parameter int CLK_PER_US = 125,
  parameter int MAX_BITS   = 32,
  parameter int PAUSE_US   = 20,
  parameter int ONE_ON_US  = 80,
  parameter int ZERO_ON_US = 40,
  parameter int TRIM_US    = 4,
  parameter int TS_W       = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [MAX_BITS-1:0]            tx_word,
  input  logic [$clog2(MAX_BITS+1)-1:0]  tx_bits,
  output logic                           carrier_on,
  output logic                           busy,
  output logic                           done,
  output logic [TS_W-1:0]                end_stamp
);
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int GAP_CYC  = (PAUSE_US - TRIM_US) * CLK_PER_US;
  localparam int ONE_CYC  = (ONE_ON_US - TRIM_US) * CLK_PER_US;
  localparam int ZERO_CYC = (ZERO_ON_US - TRIM_US) * CLK_PER_US;
  localparam int MAX_A    = (ONE_CYC > ZERO_CYC) ? ONE_CYC : ZERO_CYC;
  localparam int MAX_CYC  = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int TMR_W    = $clog2(MAX_CYC + 1);

  logic [TS_W-1:0]  us_now;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;

  pwe_us_clock #(.CLK_PER_US(CLK_PER_US), .TS_W(TS_W)) u_us (
    .clk    (clk),
    .rst    (rst),
    .us_now (us_now)
  );

  pwe_seg_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pwe_frame_seq #(
    .DATA_W  (MAX_BITS),
    .CNT_W   (CNT_W),
    .TMR_W   (TMR_W),
    .TS_W    (TS_W),
    .GAP_LD  (TMR_W'(GAP_CYC - 1)),
    .ONE_LD  (TMR_W'(ONE_CYC - 1)),
    .ZERO_LD (TMR_W'(ZERO_CYC - 1))
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .word_in     (tx_word),
    .bits_in     (tx_bits),
    .tmr_expired (tmr_expired),
    .us_now      (us_now),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .carrier_on  (carrier_on),
    .busy        (busy),
    .done        (done),
    .end_stamp   (end_stamp)
  );
endmodule

// File: rtl/pwe_checker.sv
module pwe_checker #(
  parameter int CLK_PER_US = 125,
  parameter int PAUSE_US   = 20,
  parameter int ONE_ON_US  = 80,
  parameter int ZERO_ON_US = 40,
  parameter int TRIM_US    = 4,
  parameter int TS_W       = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            carrier_on,
  input logic            busy,
  input logic            done,
  input logic [TS_W-1:0] end_stamp
);
  localparam int GAP_CYC  = (PAUSE_US - TRIM_US) * CLK_PER_US;
  localparam int ONE_CYC  = (ONE_ON_US - TRIM_US) * CLK_PER_US;
  localparam int ZERO_CYC = (ZERO_ON_US - TRIM_US) * CLK_PER_US;

  logic [31:0] low_run;
  logic [31:0] high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      high_run <= '0;
    end else if (carrier_on) begin
      low_run  <= '0;
      high_run <= high_run + 1'b1;
    end else begin
      high_run <= '0;
      low_run  <= low_run + 1'b1;
    end
  end

  AST_IDLE_CARRIER: assert property (@(posedge clk) disable iff (rst) !busy |-> carrier_on); // R1
  AST_GAP_LEN: assert property (@(posedge clk) disable iff (rst) $rose(carrier_on) |-> low_run == 32'(GAP_CYC)); // R2
  AST_ON_LEN: assert property (@(posedge clk) disable iff (rst) ($fell(carrier_on) && $past(busy)) |-> (high_run == 32'(ONE_CYC) || high_run == 32'(ZERO_CYC))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy) && carrier_on)); // R9
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(end_stamp)); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && !carrier_on)); // R11
endmodule

bind pause_width_encoder pwe_checker #(
  .CLK_PER_US (CLK_PER_US),
  .PAUSE_US   (PAUSE_US),
  .ONE_ON_US  (ONE_ON_US),
  .ZERO_ON_US (ZERO_ON_US),
  .TRIM_US    (TRIM_US),
  .TS_W       (TS_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .carrier_on (carrier_on),
  .busy       (busy),
  .done       (done),
  .end_stamp  (end_stamp)
);

// File: tb/tb_pause_width_encoder.sv
`timescale 1ns/1ps
module tb_pause_width_encoder;
  localparam int CPU   = 3;
  localparam int GAPC  = 16 * CPU;
  localparam int ONEC  = 76 * CPU;
  localparam int ZEROC = 36 * CPU;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [5:0]  tx_bits = '0;
  logic        carrier_on, busy, done;
  logic [31:0] end_stamp;

  int errors = 0;
  int checks = 0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pause_width_encoder #(.CLK_PER_US(CPU)) dut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .tx_bits(tx_bits),
    .carrier_on(carrier_on), .busy(busy), .done(done), .end_stamp(end_stamp)
  );

  // behavioural reference model
  bit          q[$];
  bit          cur_m = 1'b1, busy_m = 1'b0, done_m = 1'b0;
  longint      stamp_m = 0;
  longint      edges = 0;

  function automatic int eff_bits(input int c);
    if (c == 0) return 1;
    if (c > 32) return 32;
    return c;
  endfunction

  function automatic int frame_len(input logic [31:0] d, input int c);
    int n = eff_bits(c);
    int len = GAPC * (n + 1);
    for (int i = 0; i < n; i++) len += d[i] ? ONEC : ZEROC;
    return len;
  endfunction

  task automatic build(input logic [31:0] d, input int c);
    int n = eff_bits(c);
    for (int j = 0; j < GAPC; j++) q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      int h = d[i] ? ONEC : ZEROC;
      for (int j = 0; j < h; j++) q.push_back(1'b1);
      for (int j = 0; j < GAPC; j++) q.push_back(1'b0);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); cur_m = 1'b1; busy_m = 1'b0; done_m = 1'b0; stamp_m = 0; edges = 0;
    end else begin
      edges++;
      done_m = 1'b0;
      if (busy_m) begin
        if (q.size() > 0) cur_m = q.pop_front();
        else begin
          cur_m = 1'b1; busy_m = 1'b0; done_m = 1'b1; stamp_m = (edges - 1) / CPU;
        end
      end else if (start) begin
        build(tx_word, int'(tx_bits));
        cur_m = q.pop_front();
        busy_m = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !finished) begin
      check(carrier_on == cur_m, "R2 R3 R4 R5 R6 carrier_on", carrier_on, cur_m);
      check(busy == busy_m, "R11 busy", busy, busy_m);
      check(done == done_m, "R9 done", done, done_m);
      check(end_stamp == stamp_m[31:0], "R10 end_stamp", end_stamp, stamp_m);
    end
  end

  task automatic pulse_start(input logic [31:0] d, input logic [5:0] c);
    tx_word = d; tx_bits = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] d, input logic [5:0] c, input string tag);
    int cnt = 0;
    tx_word = d; tx_bits = c; start = 1'b1;
    do begin
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end while (!done && cnt < 20000);
    check(cnt == frame_len(d, int'(c)) + 1, tag, cnt, frame_len(d, int'(c)) + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(carrier_on == 1'b1, "R1 carrier after reset", carrier_on, 1);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(end_stamp == 0, "R1 stamp after reset", end_stamp, 0);
    chk_en = 1'b1;
    repeat (5) @(negedge clk);

    run_frame(32'h0000_00A5, 6'd8, "R5 R6 mixed byte length");
    run_frame(32'hFFFF_FFFF, 6'd32, "R3 R6 all ones length");
    run_frame(32'h0000_0000, 6'd12, "R4 R6 all zeros length");
    run_frame(32'h0000_0001, 6'd0, "R7 count zero clamps to one");
    run_frame(32'h8000_0001, 6'd45, "R7 count above max clamps");
    check(end_stamp > 0, "R10 stamp advanced", end_stamp, 1);

    // R8: start during a frame has no effect on its length
    begin
      int cnt = 0;
      tx_word = 32'h0000_0003; tx_bits = 6'd2; start = 1'b1;
      @(negedge clk); start = 1'b0; cnt = 1;
      repeat (60) begin @(negedge clk); cnt++; end
      tx_word = 32'hFFFF_FFFF; tx_bits = 6'd32; start = 1'b1;
      @(negedge clk); start = 1'b0; cnt++;
      while (!done && cnt < 20000) begin @(negedge clk); cnt++; end
      check(cnt == frame_len(32'h3, 2) + 1, "R8 mid-frame start ignored", cnt, frame_len(32'h3, 2) + 1);
    end
    repeat (3) @(negedge clk);

    // R8: start in the last cycle of the closing gap is ignored
    pulse_start(32'h0000_0002, 6'd3);
    while (!(busy_m && q.size() == 0)) @(negedge clk);
    pulse_start(32'h0000_00FF, 6'd8);
    check(done == 1'b1, "R8 done after final-cycle start", done, 1);
    @(negedge clk);
    check(busy == 1'b0, "R8 final-cycle start ignored", busy, 0);
    check(carrier_on == 1'b1, "R8 carrier idle after ignored start", carrier_on, 1);
    repeat (3) @(negedge clk);

    // R9: start in the done cycle is accepted
    pulse_start(32'h0000_0001, 6'd1);
    while (!done) @(negedge clk);
    pulse_start(32'h0000_0000, 6'd1);
    check(busy == 1'b1, "R9 start in done cycle accepted", busy, 1);
    check(carrier_on == 1'b0, "R2 gap starts after accept", carrier_on, 0);
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule